// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory

This block is a clocked model of a byte-wide static memory. It has a word address, a separate data-in and data-out path, and four control inputs: an active-low select, an active-high select, an active-low write strobe and an active-low output strobe. On every clock edge it samples the controls and decodes them into one of four modes. In deselected mode either select is inactive. In write mode both selects are active and the write strobe is low. In read mode both selects are active, the write strobe is high and the output strobe is low. In output-off mode both selects are active and both strobes are high. A write takes priority over the output strobe, so the output driver is never enabled during a write.

Read data reaches `dOut` a fixed number of cycles after the sampling edge, set by `READ_LAT`. `dOutEn` marks the cycles in which a board-level driver should drive the shared bus. `pwrDown` reports deselection. The memory holds its contents through deselected and output-off periods. When `ZERO_INIT` is set, reset clears the array. Otherwise, unwritten words read as unknown in simulation. The full part has 17 address bits. The default `ADDR_W` is smaller so that the default build stays light, and it can be set to 17 for the full size.

Top module: `dual_ce_sram`

## Requirements
- R1: When the edge samples `selLowN`=0, `selHigh`=1 and `wrN`=0, `dIn` is stored at `addr`. The value of `outEnN` does not matter.
- R2: When the edge samples `selLowN`=0, `selHigh`=1, `wrN`=1 and `outEnN`=0, the word at `addr` appears on `dOut` with `dOutEn`=1 exactly `READ_LAT` edges after that edge.
- R3: `READ_LAT` edges after an edge that samples a deselect, `outEnN`=1, or a write, `dOutEn` is 0. This holds for a write even when `outEnN`=0.
- R4: While `selLowN`=1 or `selHigh`=0, no word is written, whatever `wrN`, `addr` and `dIn` are.
- R5: `pwrDown` is 1 in the cycle after an edge that samples a deselect, and 0 in the cycle after an edge that samples both selects active.
- R6: When reads on consecutive edges change only `addr`, each new address's word appears on `dOut` one cycle after the previous one, with no extra strobe.
- R7: `dOut` keeps its last value in every cycle in which `dOutEn` is 0.
- R8: Stored words are unchanged after any number of deselected or output-off cycles.
- R9: While `rstN` is low, `dOutEn`=0, `pwrDown`=1 and `dOut`=0. With `ZERO_INIT`=1, every word reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; controls sampled on rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| dIn | input | DATA_W | Write data from the bus |
| selLowN | input | 1 | Active-low select |
| selHigh | input | 1 | Active-high select |
| wrN | input | 1 | Active-low write strobe |
| outEnN | input | 1 | Active-low output strobe |
| dOut | output | DATA_W | Read data toward the bus |
| dOutEn | output | 1 | High when the bus should be driven |
| pwrDown | output | 1 | High while deselected |

## Verification
The bench builds the block with `ADDR_W`=6, `DATA_W`=8, `READ_LAT`=2 and `ZERO_INIT`=1. The 64-word array lets the bench write and read back every address. Reset clearing gives defined read-back of words never written. A latency of two keeps a read and the following mode change in flight together, so both the pipelined output enable and the data hold during a read-to-write switch are checked.

// File: rtl/dce_sram_pkg.sv
package dce_sram_pkg;

  typedef enum logic [1:0] {
    MODE_OFFLINE = 2'd0,
    MODE_STORE   = 2'd1,
    MODE_FETCH   = 2'd2,
    MODE_QUIET   = 2'd3
  } sram_mode_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic off;
  } sram_strobe_t;

  // The write strobe outranks the output strobe.
  function automatic sram_mode_e decodeMode(input logic selLowN, input logic selHigh,
                                            input logic wrN, input logic outEnN);
    if (selLowN || !selHigh) return MODE_OFFLINE;
    if (!wrN)                return MODE_STORE;
    if (!outEnN)             return MODE_FETCH;
    return MODE_QUIET;
  endfunction

endpackage

// File: rtl/dce_sram_ctrl.sv
module dce_sram_ctrl
  import dce_sram_pkg::*;
#(
  parameter int READ_LAT = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                selLowN,
  input  logic                selHigh,
  input  logic                wrN,
  input  logic                outEnN,
  output sram_strobe_t        stb,
  output logic [READ_LAT-1:0] stageLoad,
  output logic                dOutEn,
  output logic                pwrDown
);

  sram_mode_e          mode;
  logic [READ_LAT-1:0] enQ;

  always_comb begin
    mode    = decodeMode(selLowN, selHigh, wrN, outEnN);
    stb.wr  = (mode == MODE_STORE);
    stb.rd  = (mode == MODE_FETCH);
    stb.off = (mode == MODE_OFFLINE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ[0]  <= 1'b0;
      pwrDown <= 1'b1;
    end else begin
      enQ[0]  <= stb.rd;
      pwrDown <= stb.off;
    end
  end

  assign stageLoad[0] = stb.rd;

  for (genvar i = 1; i < READ_LAT; i++) begin : g_enPipe
    always_ff @(posedge clk) begin
      if (!rstN) enQ[i] <= 1'b0;
      else       enQ[i] <= enQ[i-1];
    end
    assign stageLoad[i] = enQ[i-1];
  end

  assign dOutEn = enQ[READ_LAT-1];

endmodule

// File: rtl/dce_sram_dp.sv
module dce_sram_dp
  import dce_sram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int READ_LAT  = 1,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  sram_strobe_t        stb,
  input  logic [READ_LAT-1:0] stageLoad,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dIn,
  output logic [DATA_W-1:0]   dOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [DATA_W-1:0] pipe [READ_LAT];

  if (ZERO_INIT) begin : g_clearArray
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
      end else if (stb.wr) begin
        mem[addr] <= dIn;
      end
    end
  end else begin : g_plainArray
    always_ff @(posedge clk) begin
      if (stb.wr) mem[addr] <= dIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pipe[0] <= '0;
    else if (stageLoad[0]) pipe[0] <= mem[addr];
  end

  for (genvar i = 1; i < READ_LAT; i++) begin : g_dataPipe
    always_ff @(posedge clk) begin
      if (!rstN)             pipe[i] <= '0;
      else if (stageLoad[i]) pipe[i] <= pipe[i-1];
    end
  end

  assign dOut = pipe[READ_LAT-1];

endmodule

// File: rtl/dual_ce_sram.sv
module dual_ce_sram
  import dce_sram_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int READ_LAT  = 1,
  parameter bit ZERO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dIn,
  input  logic              selLowN,
  input  logic              selHigh,
  input  logic              wrN,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              pwrDown
);

  sram_strobe_t        stb;
  logic [READ_LAT-1:0] stageLoad;

  dce_sram_ctrl #(.READ_LAT(READ_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh),
    .wrN(wrN), .outEnN(outEnN), .stb(stb), .stageLoad(stageLoad),
    .dOutEn(dOutEn), .pwrDown(pwrDown)
  );

  dce_sram_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .READ_LAT(READ_LAT), .ZERO_INIT(ZERO_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stageLoad(stageLoad),
    .addr(addr), .dIn(dIn), .dOut(dOut)
  );

endmodule

// File: rtl/dce_sram_chk.sv
module dce_sram_chk #(
  parameter int DATA_W   = 8,
  parameter int READ_LAT = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              selLowN,
  input logic              selHigh,
  input logic              wrN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dOut,
  input logic              dOutEn,
  input logic              pwrDown,
  input logic              wrStb,
  input logic              rdStb
);

  logic [READ_LAT-1:0] shadowQ;
  logic                portRead;

  assign portRead = !selLowN && selHigh && wrN && !outEnN;

  always_ff @(posedge clk) begin
    if (!rstN) shadowQ <= '0;
    else       shadowQ <= {shadowQ[READ_LAT-2+1-1:0], portRead} ;
  end

  p_en_track_r2: assert property (@(posedge clk) disable iff (!rstN)
    dOutEn == shadowQ[READ_LAT-1]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dOutEn |-> $stable(dOut));

  p_write_blocks_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!selLowN && selHigh && !wrN) |-> !rdStb);

  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrStb, rdStb}));

  p_desel_nowrite_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selLowN || !selHigh) |-> !wrStb);

  p_pwr_on_r5: assert property (@(posedge clk) disable iff (!rstN)
    (selLowN || !selHigh) |=> pwrDown);

  p_pwr_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!selLowN && selHigh) |=> !pwrDown);

endmodule

bind dual_ce_sram dce_sram_chk #(.DATA_W(DATA_W), .READ_LAT(READ_LAT)) u_chk (
  .clk(clk), .rstN(rstN), .selLowN(selLowN), .selHigh(selHigh), .wrN(wrN),
  .outEnN(outEnN), .dOut(dOut), .dOutEn(dOutEn), .pwrDown(pwrDown),
  .wrStb(stb.wr), .rdStb(stb.rd)
);

// File: tb/sim_dual_ce_sram.sv
module sim_dual_ce_sram;

  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int LAT   = 2;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC  = 10;

  // {selLowN, selHigh, wrN, outEnN, addr, data}
  localparam logic [4+AW+DW-1:0] VEC [NVEC] = '{
    {4'b0101, 6'd1,  8'h3C},
    {4'b0101, 6'd2,  8'hC3},
    {4'b0100, 6'd63, 8'hFF},
    {4'b0101, 6'd0,  8'h81},
    {4'b0110, 6'd1,  8'h00},
    {4'b0110, 6'd2,  8'h00},
    {4'b0110, 6'd63, 8'h00},
    {4'b0110, 6'd0,  8'h00},
    {4'b0111, 6'd2,  8'h00},
    {4'b0110, 6'd2,  8'h00}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic          selLowN = 1'b1, selHigh = 1'b0, wrN = 1'b1, outEnN = 1'b1;
  logic [DW-1:0] dOut;
  logic          dOutEn, pwrDown;

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 0;

  logic [DW-1:0] refMem [DEPTH];
  bit            refEn  [LAT];
  logic [DW-1:0] refDat [LAT];
  bit            refPwr = 1'b1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  dual_ce_sram #(.ADDR_W(AW), .DATA_W(DW), .READ_LAT(LAT), .ZERO_INIT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .dIn(dIn), .selLowN(selLowN),
    .selHigh(selHigh), .wrN(wrN), .outEnN(outEnN), .dOut(dOut),
    .dOutEn(dOutEn), .pwrDown(pwrDown)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input logic sLN, input logic sH, input logic wN, input logic oN,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    bit isRd, isWr, isOff;
    @(negedge clk);
    selLowN = sLN; selHigh = sH; wrN = wN; outEnN = oN; addr = a; dIn = d;
    isOff = sLN || !sH;
    isWr  = !isOff && !wN;
    isRd  = !isOff && wN && !oN;
    for (int i = LAT-1; i >= 1; i--) begin
      if (refEn[i-1]) refDat[i] = refDat[i-1];
      refEn[i] = refEn[i-1];
    end
    if (isRd) refDat[0] = refMem[a];
    refEn[0] = isRd;
    if (isWr) refMem[a] = d;
    refPwr = isOff;
    @(posedge clk);
    #2;
    chk({tag, " R3 dOutEn"}, {7'd0, dOutEn}, {7'd0, refEn[LAT-1]});
    chk("R5 pwrDown", {7'd0, pwrDown}, {7'd0, refPwr});
    chk({tag, " R7 dOut"}, dOut, refDat[LAT-1]);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1, 1'b1, '0, '0, tag);
  endtask

  initial begin
    for (int w = 0; w < DEPTH; w++) refMem[w] = '0;
    for (int i = 0; i < LAT; i++) begin refEn[i] = 0; refDat[i] = '0; end

    // R9: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R9 dOutEn", {7'd0, dOutEn}, 8'd0);
    chk("R9 pwrDown", {7'd0, pwrDown}, 8'd1);
    chk("R9 dOut", dOut, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R9: cleared word reads zero
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'd40, 8'h00, "R9");
    idle(LAT, "R9");
    chk("R9 cleared word", dOut, 8'h00);

    // Vector table: writes (R1, one with outEnN low for R3), then reads (R2)
    for (int v = 0; v < NVEC; v++) begin
      logic [4+AW+DW-1:0] e;
      e = VEC[v];
      step(e[4+AW+DW-1], e[4+AW+DW-2], e[4+AW+DW-3], e[4+AW+DW-4],
           e[AW+DW-1:DW], e[DW-1:0], e[4+AW+DW-3] ? "R2" : "R1");
    end
    idle(LAT, "R2");

    // All sixteen control combinations at one address (R3, R4, R5)
    for (int k = 0; k < 16; k++)
      step(k[3], k[2], k[1], k[0], 6'd9, 8'(k * 17 + 1), "R3");
    idle(LAT, "R3");

    // Deselected write attempts, then read back (R4)
    step(1'b1, 1'b1, 1'b0, 1'b0, 6'd4, 8'hEE, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, 6'd4, 8'hEE, "R4");
    step(1'b1, 1'b0, 1'b0, 1'b1, 6'd4, 8'hEE, "R4");
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'd4, 8'h00, "R4");
    idle(LAT, "R4");

    // Fill every word, then back-to-back reads with changing address (R1, R6)
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b1, 1'b0, 1'b1, AW'(a), 8'(a * 3 + 7), "R1");
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b1, 1'b1, 1'b0, AW'(DEPTH - 1 - a), 8'h00, "R6");

    // Read then write with outEnN low: enable must drop, data holds (R3, R7)
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 8'h00, "R7");
    step(1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 8'h5A, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b1, 6'd20, 8'h00, "R7");
    idle(4, "R7");

    // Retention after deselect and output-off periods (R8)
    idle(20, "R8");
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b1, 1'b1, 6'd33, 8'h00, "R8");
    for (int a = 0; a < DEPTH; a += 7)
      step(1'b0, 1'b1, 1'b1, 1'b0, AW'(a), 8'h00, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, 6'd20, 8'h00, "R8");
    idle(LAT, "R8");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    wait (cyc >= 200000);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule